// File: doc/BRIEF.md
# Tagged AES Configuration Front-End

This block sits between an upstream pusher and a block-cipher core. The pusher sends tagged writes. A configuration write copies up to 32 bytes into a 108-byte register file at a byte offset. A data write offers a 16-byte payload. The front-end decodes the control word held in the register file and infers the key size from the length of the write that lands on the key. It forwards accepted payloads to the core and releases the core's result downstream after a delay that depends on the key size.

Two groups of words in the register file decide behaviour. The control word sits at bytes 0..3, and the primary key sits at bytes 8..39. The IV, second-IV, second-key and mask words complete the file and are stored but not used. Faulty requests are refused, and each kind of fault sets its own sticky status bit. A hard-stop input returns the whole block to its reset state.

Top module: `aes_cfg_frontend`

## Requirements
- R1: After reset or a one-cycle `hard_stop`, `busy`, `out_valid`, `core_start` and `err_sts` are zero, `core_key` is zero and `core_key_size` is 0 (128-bit).
- R2: A configuration write (`wr_cfg`=1) stores byte i of `wr_data` (bits 8i+7:8i) at register byte `wr_off`+i for i < `wr_len`. Register bytes 8..39 appear on `core_key`, with byte 8 at bits 7:0. Bit 0 of the little-endian control word (bytes 0..3) drives `core_decrypt`.
- R3: A configuration write with `wr_off`+`wr_len` > 108 is refused and sets `err_sts[0]`. A write ending exactly at 108 is valid.
- R4: A configuration write at offset 8 with a length of 16, 24 or 32 sets `core_key_size` to 0, 1 or 2 respectively. Any other length at that offset sets `err_sts[1]` and leaves `core_key_size` unchanged.
- R5: A data write while control bits [16:8] differ from 1 is refused and sets `err_sts[2]`.
- R6: A data write while (control bits [7:6]) OR (control bits [28:26]) is nonzero is refused and sets `err_sts[3]`.
- R7: A data write with `wr_hdr`=1, a `wr_len` other than 16, or a nonzero `wr_inval` is refused and sets `err_sts[4]`.
- R8: On the clock edge that accepts a payload, `core_block` takes `wr_data[127:0]`, and `core_start` is high for exactly the following cycle.
- R9: `out_valid` rises exactly LAT edges after the accepting edge, where LAT is 4, 6 or 8 for key-size codes 0, 1 and 2. At that edge `out_data` captures `core_result`. Both stay held until an edge with `out_ready` high.
- R10: `busy` is high from the accepting edge until the output handshake edge. A data write seen while `busy` is refused, sets `err_sts[5]`, and does not disturb the pending result.
- R11: `hard_stop` cancels a pending result, so no output appears afterwards.
- R12: Status bits stay set until reset or `hard_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hard_stop | input | 1 | Synchronous clear of all state |
| wr_valid | input | 1 | Write present this cycle |
| wr_cfg | input | 1 | 1: configuration write, 0: data write |
| wr_off | input | 7 | Starting byte offset of a configuration write |
| wr_len | input | 6 | Number of bytes carried |
| wr_data | input | 256 | Write bytes, byte i at bits 8i+7:8i |
| wr_hdr | input | 1 | Data write is header type |
| wr_inval | input | 4 | Count of invalid bytes in a data write |
| core_start | output | 1 | One-cycle start pulse to the cipher core |
| core_block | output | 128 | Payload presented to the core |
| core_key | output | 256 | Key bytes 8..39 of the register file |
| core_key_size | output | 2 | 0: 128, 1: 192, 2: 256 bits |
| core_decrypt | output | 1 | Direction bit from the control word |
| core_result | input | 128 | Cipher core output |
| out_valid | output | 1 | Result available downstream |
| out_data | output | 128 | Result block |
| out_ready | input | 1 | Downstream accepts the result |
| busy | output | 1 | A payload is in flight or awaiting handshake |
| err_sts | output | 6 | Sticky fault bits as listed in R3 to R10 |

## Verification
The collision of interest is a new payload arriving in the same cycle as the output handshake that frees the block. The bench holds a payload on the write port at the very cycle `out_valid` and `out_ready` are both high. It expects that payload to be refused with `err_sts[5]` set, the old result to be delivered once, and no second result to follow. A second collision cuts a pending result with `hard_stop` before its latency expires. The scoreboard then reports any output that arrives with nothing queued.

// File: rtl/aes_cfg_frontend.sv
module aes_cfg_frontend #(
  parameter int WORDS   = 27,
  parameter int KEY_OFF = 8,
  parameter int LAT128  = 4,
  parameter int LAT192  = 6,
  parameter int LAT256  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hard_stop,
  input  logic         wr_valid,
  input  logic         wr_cfg,
  input  logic [6:0]   wr_off,
  input  logic [5:0]   wr_len,
  input  logic [255:0] wr_data,
  input  logic         wr_hdr,
  input  logic [3:0]   wr_inval,
  output logic         core_start,
  output logic [127:0] core_block,
  output logic [255:0] core_key,
  output logic [1:0]   core_key_size,
  output logic         core_decrypt,
  input  logic [127:0] core_result,
  output logic         out_valid,
  output logic [127:0] out_data,
  input  logic         out_ready,
  output logic         busy,
  output logic [5:0]   err_sts
);
  localparam int NB   = WORDS * 4;
  localparam int LMX  = (LAT256 > LAT192) ? ((LAT256 > LAT128) ? LAT256 : LAT128)
                                          : ((LAT192 > LAT128) ? LAT192 : LAT128);
  localparam int CW   = $clog2(LMX + 1);

  logic [7:0]    rf [NB];
  logic [CW-1:0] cnt;
  logic [1:0]    ksz;

  wire [31:0] ctl    = {rf[3], rf[2], rf[1], rf[0]};
  wire [7:0]  end_b  = {1'b0, wr_off} + {2'b0, wr_len};
  wire        cfg_go = wr_valid & wr_cfg & ~hard_stop;
  wire        dat_go = wr_valid & ~wr_cfg & ~hard_stop;
  wire        ovf    = end_b > 8'(NB);
  wire        key_at = cfg_go & ~ovf & (wr_off == 7'(KEY_OFF));
  wire        len_ok = (wr_len == 6'd16) | (wr_len == 6'd24) | (wr_len == 6'd32);
  wire        fmt_bd = wr_hdr | (wr_len != 6'd16) | (wr_inval != 4'd0);
  wire        mod_bd = ctl[16:8] != 9'd1;
  wire        ksl_bd = ({1'b0, ctl[7:6]} | ctl[28:26]) != 3'd0;
  wire        accept = dat_go & ~fmt_bd & ~mod_bd & ~ksl_bd & ~busy;

  wire [CW-1:0] lat = (ksz == 2'd0) ? CW'(LAT128) :
                      (ksz == 2'd1) ? CW'(LAT192) : CW'(LAT256);

  assign busy          = (cnt != '0) | out_valid;
  assign core_key_size = ksz;
  assign core_decrypt  = ctl[0];

  always_comb
    for (int i = 0; i < 32; i++) core_key[8*i +: 8] = rf[KEY_OFF + i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      for (int b = 0; b < NB; b++) rf[b] <= '0;
    else if (hard_stop)
      for (int b = 0; b < NB; b++) rf[b] <= '0;
    else if (cfg_go && !ovf)
      for (int b = 0; b < NB; b++)
        if (int'(wr_off) <= b && b < int'(end_b))
          rf[b] <= wr_data[{5'(b - int'(wr_off)), 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ksz <= '0;
    else if (hard_stop) ksz <= '0;
    else if (key_at && len_ok) ksz <= (wr_len == 6'd16) ? 2'd0 : (wr_len == 6'd24) ? 2'd1 : 2'd2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err_sts <= '0;
    else if (hard_stop) err_sts <= '0;
    else err_sts <= err_sts | {dat_go & busy, dat_go & fmt_bd, dat_go & ksl_bd,
                               dat_go & mod_bd, key_at & ~len_ok, cfg_go & ovf};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; core_start <= 1'b0; core_block <= '0; out_valid <= 1'b0; out_data <= '0;
    end else if (hard_stop) begin
      cnt <= '0; core_start <= 1'b0; core_block <= '0; out_valid <= 1'b0; out_data <= '0;
    end else begin
      core_start <= accept;
      if (accept) begin
        core_block <= wr_data[127:0];
        cnt        <= lat;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          out_valid <= 1'b1;
          out_data  <= core_result;
        end
      end
      if (out_valid && out_ready) out_valid <= 1'b0;
    end

  // R1 R11
  hard_stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_stop |=> (!busy && !out_valid && err_sts == 6'd0 && core_key_size == 2'd0));

  // R12
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hard_stop |=> ((err_sts & $past(err_sts)) == $past(err_sts)));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !hard_stop) |=> (out_valid && $stable(out_data)));

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (busy && $past(!busy)));

  // R9
  rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));
endmodule

// File: tb/aes_cfg_frontend_tb.sv
`timescale 1ns/1ps
module aes_cfg_frontend_tb_top;
  logic clk = 0, rst_n = 0, hard_stop = 0;
  logic wr_valid = 0, wr_cfg = 0, wr_hdr = 0;
  logic [6:0] wr_off = 0;
  logic [5:0] wr_len = 0;
  logic [255:0] wr_data = 0;
  logic [3:0] wr_inval = 0;
  logic core_start, core_decrypt, out_valid, busy;
  logic out_ready = 1;
  logic [127:0] core_block, core_result, out_data;
  logic [255:0] core_key;
  logic [1:0] core_key_size;
  logic [5:0] err_sts;

  always #2 clk = ~clk;

  aes_cfg_frontend dut_i (.*);

  assign core_result = core_block ^ core_key[127:0] ^ {128{core_decrypt}};

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [127:0] exp_d[$];
  int exp_c[$];
  logic [255:0] m_key = 0;
  logic m_dec = 0;
  logic prev_ov = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (out_valid && !prev_ov) begin
      if (exp_d.size() == 0) chk(0, "R11 unexpected output", out_data, 0);
      else begin
        chk(out_data == exp_d[0], "R9 data", out_data, exp_d[0]);
        chk(cyc == exp_c[0], "R9 latency", cyc, exp_c[0]);
        void'(exp_d.pop_front()); void'(exp_c.pop_front());
      end
    end
    prev_ov = out_valid;
  end

  task automatic cfg_wr(input int off, input int len, input logic [255:0] d);
    @(negedge clk);
    wr_valid = 1; wr_cfg = 1; wr_off = 7'(off); wr_len = 6'(len); wr_data = d;
    @(negedge clk);
    wr_valid = 0; wr_cfg = 0;
  endtask

  task automatic pay(input logic [127:0] d, input int len, input int inv, input bit hdr,
                     input bit ok, input int lat);
    @(negedge clk);
    wr_valid = 1; wr_cfg = 0; wr_len = 6'(len); wr_data = {128'h0, d};
    wr_inval = 4'(inv); wr_hdr = hdr;
    @(negedge clk);
    wr_valid = 0; wr_hdr = 0; wr_inval = 0;
    if (ok) begin
      exp_d.push_back(d ^ m_key[127:0] ^ {128{m_dec}});
      exp_c.push_back(cyc + lat);
      chk(core_start === 1'b1, "R8 start pulse", core_start, 1);
      chk(core_block == d, "R8 block", core_block, d);
    end else chk(core_start === 1'b0, "R5-7 refused, no start", core_start, 0);
  endtask

  task automatic idle();
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(!busy && exp_d.size() == 0, "R10 idle after delivery", busy, 0);
  endtask

  task automatic hstop();
    @(negedge clk); hard_stop = 1;
    @(negedge clk); hard_stop = 0;
    exp_d.delete(); exp_c.delete(); m_key = 0; m_dec = 0;
  endtask

  task automatic setup(input logic [31:0] ctlw, input int klen, input logic [255:0] k);
    cfg_wr(0, 4, {224'h0, ctlw});
    cfg_wr(8, klen, k);
    m_dec = ctlw[0];
    m_key = k;
    for (int i = klen; i < 32; i++) m_key[8*i +: 8] = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !out_valid && !core_start && err_sts == 0, "R1 reset outputs", {busy, out_valid, err_sts}, 0);
    chk(core_key == 0 && core_key_size == 0, "R1 reset key", core_key, 0);

    // R2 R4 basic 128-bit
    setup(32'h0000_0100, 16, 256'h0f0e0d0c0b0a09080706050403020100);
    chk(core_key[7:0] == 8'h00 && core_key[127:120] == 8'h0f, "R2 key byte order", core_key, m_key);
    chk(core_key_size == 2'd0, "R4 size 128", core_key_size, 0);
    pay(128'h1122_3344_5566_7788_99aa_bbcc_ddee_ff00, 16, 0, 0, 1, 4);
    idle();

    // R4 192 and 256 with latency
    setup(32'h0000_0100, 24, {64'h0, 192'hdead_beef_0123_4567_89ab_cdef_fedc_ba98_7654_3210_cafe_f00d});
    chk(core_key_size == 2'd1, "R4 size 192", core_key_size, 1);
    pay(128'h5a5a, 16, 0, 0, 1, 6);
    idle();
    setup(32'h0000_0101, 32, {128'hffee, 128'h1357_9bdf});
    chk(core_key_size == 2'd2, "R4 size 256", core_key_size, 2);
    chk(core_decrypt == 1'b1, "R2 direction bit", core_decrypt, 1);
    pay(128'habcd_ef01, 16, 0, 0, 1, 8);
    idle();

    // R4 bad key length
    cfg_wr(8, 20, 256'h77);
    @(negedge clk);
    chk(err_sts[1] && core_key_size == 2'd2, "R4 warn, size kept", {err_sts, core_key_size}, {6'b000010, 2'd2});
    m_key[7:0] = 8'h77; m_key[159:8] = m_key[159:8] & {152{1'b1}};
    m_key[159:8] = {m_key[159:128] & 32'h0, m_key[127:8]};
    chk(core_key[7:0] == 8'h77, "R2 short key write", core_key[7:0], 8'h77);

    // R3 range
    hstop();
    chk(err_sts == 0 && core_key == 0, "R1 hard stop clear", {err_sts, core_key}, 0);
    cfg_wr(100, 8, 256'h1);
    @(negedge clk);
    chk(err_sts[0] == 1'b0, "R3 exact end ok", err_sts, 0);
    cfg_wr(100, 9, 256'h1);
    @(negedge clk);
    chk(err_sts[0] == 1'b1, "R3 overflow flagged", err_sts, 1);

    // R5 mode, R12 sticky
    hstop();
    setup(32'h0000_0200, 16, 256'h42);
    pay(128'h1, 16, 0, 0, 0, 0);
    chk(err_sts == 6'b000100, "R5 mode error", err_sts, 6'b000100);
    repeat (5) @(negedge clk);
    chk(err_sts[2] && !busy, "R12 sticky, R5 nothing started", {err_sts, busy}, 1);

    // R6 keysel via both fields
    hstop();
    setup(32'h0800_0100, 16, 256'h42);
    pay(128'h2, 16, 0, 0, 0, 0);
    chk(err_sts == 6'b001000, "R6 keysel high field", err_sts, 6'b001000);
    hstop();
    setup(32'h0000_0140, 16, 256'h42);
    pay(128'h2, 16, 0, 0, 0, 0);
    chk(err_sts == 6'b001000, "R6 keysel low field", err_sts, 6'b001000);

    // R7 format faults
    hstop();
    setup(32'h0000_0100, 16, 256'h99);
    pay(128'h3, 15, 0, 0, 0, 0);
    chk(err_sts == 6'b010000, "R7 short payload", err_sts, 6'b010000);
    hstop();
    setup(32'h0000_0100, 16, 256'h99);
    pay(128'h3, 16, 1, 0, 0, 0);
    chk(err_sts == 6'b010000, "R7 invalid bytes", err_sts, 6'b010000);
    hstop();
    setup(32'h0000_0100, 16, 256'h99);
    pay(128'h3, 16, 0, 1, 0, 0);
    chk(err_sts == 6'b010000, "R7 header type", err_sts, 6'b010000);

    // R10 overrun
    hstop();
    setup(32'h0000_0100, 16, 256'h1234);
    pay(128'haaaa, 16, 0, 0, 1, 4);
    pay(128'hbbbb, 16, 0, 0, 0, 0);
    chk(err_sts[5] == 1'b1, "R10 overrun flagged", err_sts, 6'b100000);
    idle();

    // R9 hold while not ready
    out_ready = 0;
    pay(128'hcccc, 16, 0, 0, 1, 4);
    repeat (10) @(negedge clk);
    chk(out_valid && out_data == (128'hcccc ^ m_key[127:0]), "R9 held", out_data, 128'hcccc ^ m_key[127:0]);
    out_ready = 1;
    idle();

    // R10 collision: new payload during handshake cycle
    hstop();
    setup(32'h0000_0100, 16, 256'h5555);
    pay(128'hdddd, 16, 0, 0, 1, 4);
    while (!out_valid) @(negedge clk);
    wr_valid = 1; wr_cfg = 0; wr_len = 16; wr_data = 256'heeee;
    @(negedge clk);
    wr_valid = 0;
    chk(err_sts[5] && !core_start && !out_valid, "R10 collision refused", {err_sts, core_start}, 6'b100000);
    repeat (12) @(negedge clk);
    chk(!busy && !out_valid, "R10 no second result", busy, 0);

    // R11 cancel
    pay(128'hffff, 16, 0, 0, 1, 4);
    @(negedge clk);
    hstop();
    repeat (10) @(negedge clk);
    chk(!out_valid && !busy, "R11 cancelled", {out_valid, busy}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule